// File: doc/BRIEF.md
# Multiples-of-3-or-5 Cycle Accumulator

This block computes, one step per clock cycle, the sum of every natural number below a fixed limit (1000 by default) that is divisible by 3 or by 5. No constant is wired to the output. Three stepping counters advance by strides of 3, 5 and 15. Each one feeds its own accumulator. The three partial sums are then combined by inclusion–exclusion, so multiples of 15 are counted only once.

After reset the block stays idle until the start input is seen high. The run then proceeds without further input. The stride-3 chain needs the most cycles, so its completion gates the final combine. The result-valid flag rises one cycle after that chain finishes and stays high until the next reset.

Top module: `m35_acc`

## Requirements
- R1: While rst_ni is low, and right after it is released, valid_o is 0 and result_o is 0.
- R2: While en_i has never been high since reset, valid_o stays 0 and result_o stays 0.
- R3: When valid_o is 1, result_o equals the sum of all naturals below 1000 divisible by 3 or 5, which is 233168.
- R4: If en_i is first seen high at clock edge E0, then valid_o is 0 after edge E0+335 and 1 after edge E0+336. That is 334 stride-3 additions, one completion cycle and one combine cycle.
- R5: Once valid_o is 1, it stays 1 and result_o holds its value until reset.
- R6: A single-cycle pulse on en_i is enough to start a run that completes with the value of R3. Dropping en_i mid-run has no effect.
- R7: en_i held high through completion, or raised again after completion, changes neither result_o nor valid_o.
- R8: A reset in the middle of a run aborts it. A following run gives the value and timing of R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Start request; the first high sample starts the run |
| result_o | output | 18 | Sum of multiples of 3 or 5 below the limit |
| valid_o | output | 1 | High once result_o is final; sticky until reset |

## Verification
Two events can fall in the same cycle: a start request on en_i, and the completion that raises valid_o. The bench provokes this by holding en_i high through the whole run, including the edge where valid_o rises, and also by raising en_i again after completion. In both cases it judges that the rise happens at exactly edge E0+336, that the value is 233168, and that neither valid_o nor result_o moves over the following cycles. A reset in mid-run, followed by a fresh start, confirms that no partial sum leaks into the next result.

// File: rtl/m35_pkg.sv
package m35_pkg;
  localparam int unsigned NUM_CH = 3;

  // stride of channel ch: a, b, a*b (inclusion-exclusion needs coprime a, b)
  function automatic int unsigned ch_stride(int unsigned ch, int unsigned a, int unsigned b);
    if (ch == 0) return a;
    else if (ch == 1) return b;
    else return a * b;
  endfunction

  function automatic longint unsigned ref_sum(int unsigned lim, int unsigned a, int unsigned b);
    longint unsigned s = 0;
    for (int unsigned i = 0; i < lim; i++)
      if ((i % a) == 0 || (i % b) == 0) s += i;
    return s;
  endfunction
endpackage

// File: rtl/m35_stride_acc.sv
module m35_stride_acc #(
  parameter int unsigned STRIDE = 3,
  parameter int unsigned LIMIT  = 1000,
  parameter int unsigned CNT_W  = 11,
  parameter int unsigned SUM_W  = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [SUM_W-1:0] sum_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sum_q  <= '0;
      done_q <= 1'b0;
    end else if (run_i && !done_q) begin
      if (cnt_q < CNT_W'(LIMIT)) begin
        sum_q <= sum_q + SUM_W'(cnt_q);
        cnt_q <= cnt_q + CNT_W'(STRIDE);
      end else begin
        done_q <= 1'b1;
      end
    end
  end

  assign sum_o  = sum_q;
  assign done_o = done_q;
endmodule

// File: rtl/m35_combine.sv
module m35_combine #(
  parameter int unsigned SUM_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [SUM_W-1:0] sum_a_i,
  input  logic [SUM_W-1:0] sum_b_i,
  input  logic [SUM_W-1:0] sum_ab_i,
  output logic [SUM_W-1:0] result_o,
  output logic             valid_o
);
  logic [SUM_W-1:0] res_q;
  logic             vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else if (done_i && !vld_q) begin
      res_q <= sum_a_i + sum_b_i - sum_ab_i;
      vld_q <= 1'b1;
    end
  end

  assign result_o = res_q;
  assign valid_o  = vld_q;
endmodule

// File: rtl/m35_acc.sv
module m35_acc #(
  parameter int unsigned LIMIT = 1000,
  parameter int unsigned DIV_A = 3,
  parameter int unsigned DIV_B = 5,
  parameter int unsigned RES_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o
);
  import m35_pkg::*;

  localparam int unsigned MAX_STR = DIV_A * DIV_B;
  localparam int unsigned CNT_W   = $clog2(LIMIT + MAX_STR + 1);
  // DIV_A is the smallest stride, so its chain finishes last
  localparam int unsigned LEAD_CH = 0;

  logic                         run_q;
  logic [NUM_CH-1:0]            ch_done;
  logic [NUM_CH-1:0][RES_W-1:0] ch_sum;
  logic                         lead_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   run_q <= 1'b0;
    else if (en_i) run_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    m35_stride_acc #(
      .STRIDE(ch_stride(g, DIV_A, DIV_B)),
      .LIMIT (LIMIT),
      .CNT_W (CNT_W),
      .SUM_W (RES_W)
    ) u_acc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (run_q),
      .sum_o (ch_sum[g]),
      .done_o(ch_done[g])
    );
  end

  assign lead_done = ch_done[LEAD_CH];

  m35_combine #(.SUM_W(RES_W)) u_comb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (lead_done),
    .sum_a_i (ch_sum[0]),
    .sum_b_i (ch_sum[1]),
    .sum_ab_i(ch_sum[2]),
    .result_o(result_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/m35_chk.sv
module m35_chk #(
  parameter int unsigned LIMIT = 1000,
  parameter int unsigned DIV_A = 3,
  parameter int unsigned DIV_B = 5,
  parameter int unsigned RES_W = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [RES_W-1:0] result_o,
  input logic             valid_o,
  input logic             lead_done_i
);
  localparam logic [RES_W-1:0] EXP_SUM = RES_W'(m35_pkg::ref_sum(LIMIT, DIV_A, DIV_B));
  localparam int unsigned LAT = (LIMIT + DIV_A - 1) / DIV_A + 2;

  logic        started_q;
  logic [15:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      age_q     <= '0;
    end else if (!started_q) begin
      if (en_i) started_q <= 1'b1;
    end else if (age_q != 16'hffff) begin
      age_q <= age_q + 16'd1;
    end
  end

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> (!valid_o && result_o == '0));

  a_r3_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> result_o == EXP_SUM);

  a_r4_not_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (started_q && age_q >= 16'(LAT)));

  a_r4_on_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && age_q >= 16'(LAT)) |-> valid_o);

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> (valid_o && $stable(result_o)));

  a_r4_done_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> lead_done_i);
endmodule

bind m35_acc m35_chk #(
  .LIMIT(LIMIT), .DIV_A(DIV_A), .DIV_B(DIV_B), .RES_W(RES_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .result_o   (result_o),
  .valid_o    (valid_o),
  .lead_done_i(lead_done)
);

// File: tb/tb_m35_acc.sv
`timescale 1ns/1ps
module tb_m35_acc;
  localparam int RES_W = 18;
  localparam int LAT   = 336;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic [RES_W-1:0] result_o;
  logic             valid_o;

  int n_chk = 0;
  int n_err = 0;
  logic [RES_W-1:0] exp_sum;

  always #5 clk_i = ~clk_i;

  m35_acc dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .result_o(result_o), .valid_o(valid_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    en_i   = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // start at a negedge; returns index k of the edge after E0 where valid rose
  task automatic run(input bit pulse, output int rise_k);
    rise_k = -1;
    en_i = 1'b1;
    @(negedge clk_i);
    if (pulse) en_i = 1'b0;
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk_i);
      if (valid_o && rise_k < 0) rise_k = k;
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk_i);
    rst_ni = 1'b0;
    check("R1 valid in reset", valid_o, 0);
    check("R1 result in reset", result_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 valid after release", valid_o, 0);
    check("R1 result after release", result_o, 0);
  endtask

  task automatic t_idle();
    int bad = 0;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk_i);
      if (valid_o || result_o != 0) bad++;
    end
    check("R2 idle without enable", bad, 0);
  endtask

  task automatic t_held_run();
    int rk;
    logic [RES_W-1:0] snap;
    run(1'b0, rk);
    check("R4 valid rise edge (en held)", rk, LAT);
    check("R3 result value", result_o, exp_sum);
    snap = result_o;
    repeat (50) @(negedge clk_i);
    check("R7 en held, result unchanged", result_o, snap);
    check("R7 en held, valid kept", valid_o, 1);
    en_i = 1'b0;
    repeat (5) @(negedge clk_i);
    en_i = 1'b1;
    repeat (5) @(negedge clk_i);
    en_i = 1'b0;
    check("R7 re-enable, result unchanged", result_o, snap);
    check("R5 valid sticky", valid_o, 1);
  endtask

  task automatic t_pulse_run();
    int rk;
    logic [RES_W-1:0] snap;
    run(1'b1, rk);
    check("R6 pulse start, rise edge", rk, LAT);
    check("R6 pulse start, result", result_o, exp_sum);
    snap = result_o;
    repeat (200) @(negedge clk_i);
    check("R5 result stable", result_o, snap);
    check("R5 valid stable", valid_o, 1);
  endtask

  task automatic t_early();
    int seen = 0;
    en_i = 1'b1;
    @(negedge clk_i);
    en_i = 1'b0;
    for (int k = 1; k <= 335; k++) begin
      @(negedge clk_i);
      if (valid_o) seen++;
    end
    check("R4 no valid through E0+335", seen, 0);
    @(negedge clk_i);
    check("R4 valid after E0+336", valid_o, 1);
  endtask

  task automatic t_abort();
    int rk;
    en_i = 1'b1;
    @(negedge clk_i);
    en_i = 1'b0;
    repeat (120) @(negedge clk_i);
    do_reset();
    check("R8 valid cleared by abort", valid_o, 0);
    check("R8 result cleared by abort", result_o, 0);
    @(negedge clk_i);
    run(1'b1, rk);
    check("R8 rerun rise edge", rk, LAT);
    check("R8 rerun result", result_o, exp_sum);
  endtask

  initial begin
    exp_sum = '0;
    for (int i = 0; i < 1000; i++)
      if (i % 3 == 0 || i % 5 == 0) exp_sum += RES_W'(i);
    check("R3 reference constant", exp_sum, 233168);

    t_reset_state();
    t_idle();
    t_held_run();
    do_reset();
    @(negedge clk_i);
    t_pulse_run();
    do_reset();
    @(negedge clk_i);
    t_early();
    do_reset();
    @(negedge clk_i);
    t_abort();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule